// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sits next to a microcontroller CPU core and chooses which low-power state the device enters when software writes the mode-control register. A single register write carries three request bits: stop, sleep and an active-low timer-mode request. The controller resolves priority among them. For a sleep request, it also looks at the current clock-source selection to choose a PLL, main-oscillator or sub-oscillator sleep flavour. From the resolved state it drives registered clock enables for the CPU, the peripherals and the timebase/watch timer. It also drives a per-pin output-freeze enable and a bus-hold acknowledge.

If an interrupt is already pending when the request is evaluated, entry is refused and the core keeps running. While the controller is in any low-power state, a pending interrupt returns it to run on the next clock edge. The request bits clear themselves once the controller has acted on them, so software reading the register back sees them return to idle.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: Reset places the controller in RUN. The state output is one-hot with RUN=bit0, PLL_SLEEP=bit1, MAIN_SLEEP=bit2, SUB_SLEEP=bit3, TIMER=bit4 and STOP=bit5. Exactly one bit is set at all times.
- R2: A write with sleep=1, tmr_req_n=1 and stop=0 in RUN enters a sleep flavour. osc_fast_sel=0 selects SUB_SLEEP. osc_fast_sel=1 with osc_main_sel=1 selects MAIN_SLEEP. osc_fast_sel=1 with osc_main_sel=0 selects PLL_SLEEP.
- R3: A write with stop=1 enters STOP, whatever the values of the sleep and tmr_req_n bits.
- R4: A write with stop=0 and tmr_req_n=0 enters TIMER, even when sleep=1.
- R5: If irq_pend is high in the cycle the request is evaluated, no transition occurs and the state stays RUN.
- R6: In any non-RUN state, irq_pend high returns the state to RUN on the next clock edge, and cpu_clk_en returns to 1 in the same cycle.
- R7: Clock enables follow the state. RUN gives cpu=1, periph=1, timer=1. Any sleep flavour gives cpu=0, periph=1, timer=1. TIMER gives cpu=0, periph=0, timer=1. STOP gives all three 0.
- R8: In a sleep flavour, pin_freeze is high for every pin whose BUS_PIN_MASK bit is 0 and low for bus pins. In RUN, TIMER and STOP it is all zeros.
- R9: hold_ack follows hold_req one cycle later while the state is RUN or a sleep flavour. It is 0 in TIMER and STOP.
- R10: The request readback req_rd ({stop, tmr_req_n, sleep}) shows the written bits in the cycle after a write. It returns to idle 3'b010 one cycle later.
- R11: A request written while the state is not RUN is discarded, and the state is unchanged.
- R12: A write with stop=0, tmr_req_n=1 and sleep=0 leaves the state in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode-register write strobe |
| wr_stop | input | 1 | Stop request bit |
| wr_tmr_req_n | input | 1 | Timer-mode request, active low |
| wr_sleep | input | 1 | Sleep request bit |
| osc_main_sel | input | 1 | 1 = main oscillator, 0 = PLL (when the fast clock is selected) |
| osc_fast_sel | input | 1 | 1 = fast clock (main/PLL), 0 = sub oscillator |
| irq_pend | input | 1 | Interrupt request pending |
| hold_req | input | 1 | External bus hold request |
| lpm_state | output | 6 | One-hot power state |
| req_rd | output | 3 | Request readback {stop, tmr_req_n, sleep} |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tb_clk_en | output | 1 | Timebase/watch timer clock enable |
| hold_ack | output | 1 | Bus hold acknowledge |
| pin_freeze | output | N_PINS | Per-pin output freeze enable |

## Verification
A write takes two register stages. The readback shows the written bits one cycle after the strobe edge. The new state and all clock, freeze and hold outputs change together on the following edge, so they are due two cycles after the write. A wake-up through irq_pend reaches the state and the clock enables one edge after the interrupt is sampled. The driver tags each expected item with the cycle in which it is due. The monitor compares on the falling clock edge of exactly that cycle, and it reports an item whose due cycle has already passed as a failure.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [5:0] {
    ST_RUN      = 6'b000001,
    ST_PLL_SLP  = 6'b000010,
    ST_MAIN_SLP = 6'b000100,
    ST_SUB_SLP  = 6'b001000,
    ST_TMR      = 6'b010000,
    ST_STOP     = 6'b100000
  } lpm_state_e;

  typedef struct packed {
    logic stop;
    logic tmr_n;
    logic sleep;
  } lpm_req_t;

  localparam lpm_req_t REQ_IDLE = '{stop: 1'b0, tmr_n: 1'b1, sleep: 1'b0};

  function automatic logic st_is_sleep(input lpm_state_e s);
    return (s == ST_PLL_SLP) || (s == ST_MAIN_SLP) || (s == ST_SUB_SLP);
  endfunction

endpackage

// File: rtl/lpm_req_reg.sv
module lpm_req_reg
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  lpm_req_t wr_req,
  output lpm_req_t req_q,
  output logic     req_vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= REQ_IDLE;
      req_vld <= 1'b0;
    end else if (wr_en) begin
      req_q   <= wr_req;
      req_vld <= 1'b1;
    end else if (req_vld) begin
      req_q   <= REQ_IDLE;
      req_vld <= 1'b0;
    end
  end

  // R10
  req_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !wr_en) |=> (!req_vld && req_q == REQ_IDLE));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_vld,
  input  lpm_req_t   req_q,
  input  logic       irq_pend,
  input  logic       osc_main_sel,
  input  logic       osc_fast_sel,
  output lpm_state_e state_q,
  output lpm_state_e state_nx
);

  lpm_state_e sleep_kind;

  always_comb begin
    if (!osc_fast_sel)     sleep_kind = ST_SUB_SLP;
    else if (osc_main_sel) sleep_kind = ST_MAIN_SLP;
    else                   sleep_kind = ST_PLL_SLP;
  end

  always_comb begin
    state_nx = state_q;
    if (state_q != ST_RUN) begin
      if (irq_pend) state_nx = ST_RUN;
    end else if (req_vld && !irq_pend) begin
      if (req_q.stop)        state_nx = ST_STOP;
      else if (!req_q.tmr_n) state_nx = ST_TMR;
      else if (req_q.sleep)  state_nx = sleep_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_nx;
  end

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  // R5
  irq_blocks_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && req_vld && irq_pend) |=> state_q == ST_RUN);

  // R3
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && req_vld && !irq_pend && req_q.stop) |=> state_q == ST_STOP);

  // R4
  timer_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && req_vld && !irq_pend && !req_q.stop && !req_q.tmr_n)
      |=> state_q == ST_TMR);

  // R6
  irq_wakes_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN && irq_pend) |=> state_q == ST_RUN);

  // R11
  lowpwr_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN && !irq_pend) |=> $stable(state_q));

endmodule

// File: rtl/lpm_out_map.sv
module lpm_out_map
  import lpm_pkg::*;
#(
  parameter int                N_PINS       = 16,
  parameter logic [N_PINS-1:0] BUS_PIN_MASK = 16'h00FF
)(
  input  logic              clk,
  input  logic              rst,
  input  lpm_state_e        state_nx,
  input  logic              hold_req,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              tb_clk_en,
  output logic              hold_ack,
  output logic [N_PINS-1:0] pin_freeze
);

  logic nx_sleep;
  logic nx_bus_live;

  assign nx_sleep    = st_is_sleep(state_nx);
  assign nx_bus_live = nx_sleep || (state_nx == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= 1'b1;
      tb_clk_en     <= 1'b1;
      hold_ack      <= 1'b0;
    end else begin
      cpu_clk_en    <= (state_nx == ST_RUN);
      periph_clk_en <= nx_bus_live;
      tb_clk_en     <= (state_nx != ST_STOP);
      hold_ack      <= hold_req && nx_bus_live;
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    if (BUS_PIN_MASK[p]) begin : g_bus
      assign pin_freeze[p] = 1'b0;
    end else begin : g_gpio
      logic frz_q;
      always_ff @(posedge clk) begin
        if (rst) frz_q <= 1'b0;
        else     frz_q <= nx_sleep;
      end
      assign pin_freeze[p] = frz_q;
    end
  end

  // R7
  stop_gates_all_chk: assert property (@(posedge clk) disable iff (rst)
    !tb_clk_en |-> (!periph_clk_en && !cpu_clk_en));

  // R9
  hold_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack) |-> $past(hold_req));

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int                N_PINS       = 16,
  parameter logic [N_PINS-1:0] BUS_PIN_MASK = 16'h00FF
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_stop,
  input  logic              wr_tmr_req_n,
  input  logic              wr_sleep,
  input  logic              osc_main_sel,
  input  logic              osc_fast_sel,
  input  logic              irq_pend,
  input  logic              hold_req,
  output logic [5:0]        lpm_state,
  output logic [2:0]        req_rd,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              tb_clk_en,
  output logic              hold_ack,
  output logic [N_PINS-1:0] pin_freeze
);

  lpm_req_t   wr_req;
  lpm_req_t   req_q;
  logic       req_vld;
  lpm_state_e state_q;
  lpm_state_e state_nx;

  assign wr_req = '{stop: wr_stop, tmr_n: wr_tmr_req_n, sleep: wr_sleep};

  lpm_req_reg u_req (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_req  (wr_req),
    .req_q   (req_q),
    .req_vld (req_vld)
  );

  lpm_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_vld      (req_vld),
    .req_q        (req_q),
    .irq_pend     (irq_pend),
    .osc_main_sel (osc_main_sel),
    .osc_fast_sel (osc_fast_sel),
    .state_q      (state_q),
    .state_nx     (state_nx)
  );

  lpm_out_map #(
    .N_PINS       (N_PINS),
    .BUS_PIN_MASK (BUS_PIN_MASK)
  ) u_out (
    .clk           (clk),
    .rst           (rst),
    .state_nx      (state_nx),
    .hold_req      (hold_req),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .tb_clk_en     (tb_clk_en),
    .hold_ack      (hold_ack),
    .pin_freeze    (pin_freeze)
  );

  assign lpm_state = state_q;
  assign req_rd    = req_q;

  // R6
  cpu_clk_tracks_run_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en == (state_q == ST_RUN));

  // R8
  bus_pins_live_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_freeze & BUS_PIN_MASK) == '0);

  // R8
  freeze_only_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_freeze != '0) |-> st_is_sleep(state_q));

endmodule

// File: tb/lpm_entry_ctrl_tb.sv
module lpm_entry_ctrl_tb;

  localparam int             NP = 16;
  localparam logic [NP-1:0]  BM = 16'h00FF;
  localparam logic [5:0] S_RUN = 6'd1, S_PLL = 6'd2, S_MAIN = 6'd4,
                         S_SUB = 6'd8, S_TMR = 6'd16, S_STOP = 6'd32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_stop = 0, wr_tmr_req_n = 1, wr_sleep = 0;
  logic osc_main_sel = 0, osc_fast_sel = 1, irq_pend = 0, hold_req = 0;
  logic [5:0]    lpm_state;
  logic [2:0]    req_rd;
  logic          cpu_clk_en, periph_clk_en, tb_clk_en, hold_ack;
  logic [NP-1:0] pin_freeze;

  always #2 clk = ~clk;

  lpm_entry_ctrl #(.N_PINS(NP), .BUS_PIN_MASK(BM)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_stop(wr_stop),
    .wr_tmr_req_n(wr_tmr_req_n), .wr_sleep(wr_sleep),
    .osc_main_sel(osc_main_sel), .osc_fast_sel(osc_fast_sel),
    .irq_pend(irq_pend), .hold_req(hold_req), .lpm_state(lpm_state),
    .req_rd(req_rd), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .tb_clk_en(tb_clk_en), .hold_ack(hold_ack), .pin_freeze(pin_freeze)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          rb;
    logic [25:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [25:0] exp_out(input logic [5:0] st, input logic hold);
    logic slp, live;
    slp  = (st == S_PLL) || (st == S_MAIN) || (st == S_SUB);
    live = slp || (st == S_RUN);
    return {st, st == S_RUN, live, st != S_STOP, hold && live,
            slp ? ~BM : {NP{1'b0}}};
  endfunction

  task automatic push_out(input int due, input logic [5:0] st, input string tag);
    exp_t e;
    e.due = due; e.rb = 1'b0; e.val = exp_out(st, hold_req); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_rb(input int due, input logic [2:0] v, input string tag);
    exp_t e;
    e.due = due; e.rb = 1'b1; e.val = {23'd0, v}; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    exp_t e;
    logic [25:0] got;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      got = e.rb ? {23'd0, req_rd}
                 : {lpm_state, cpu_clk_en, periph_clk_en, tb_clk_en, hold_ack, pin_freeze};
      checks++;
      if (e.due != cyc || got !== e.val) begin
        errors++;
        $display("FAIL %s: got %h expected %h (due %0d at %0d)", e.tag, got, e.val, e.due, cyc);
      end
    end
  end

  // write request, expected state two cycles later
  task automatic do_write(input logic s, input logic tn, input logic sl,
                          input logic [5:0] exp_st, input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    wr_en = 1; wr_stop = s; wr_tmr_req_n = tn; wr_sleep = sl;
    push_rb(c + 1, {s, tn, sl}, {tag, " R10 readback"});
    push_rb(c + 2, 3'b010, {tag, " R10 idle"});
    push_out(c + 2, exp_st, tag);
    @(negedge clk);
    wr_en = 0; wr_stop = 0; wr_tmr_req_n = 1; wr_sleep = 0;
    @(negedge clk);
  endtask

  task automatic do_wake(input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    irq_pend = 1;
    push_out(c + 1, S_RUN, tag);
    @(negedge clk);
    irq_pend = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    push_out(cyc + 1, S_RUN, "R1 reset state");
    push_rb(cyc + 1, 3'b010, "R1 reset readback");
    @(negedge clk);

    // R2 PLL sleep
    osc_fast_sel = 1; osc_main_sel = 0;
    do_write(0, 1, 1, S_PLL, "R2 PLL sleep R7 R8");
    do_wake("R6 wake from PLL sleep");
    // R2 main sleep with hold, R9
    osc_main_sel = 1; hold_req = 1;
    do_write(0, 1, 1, S_MAIN, "R2 main sleep R9 hold");
    do_wake("R6 wake from main sleep");
    // R2 sub sleep
    osc_fast_sel = 0;
    do_write(0, 1, 1, S_SUB, "R2 sub sleep");
    // R11 write while sleeping discarded
    do_write(1, 0, 0, S_SUB, "R11 ignored in sleep");
    do_wake("R6 wake from sub sleep");
    // R3 stop beats sleep, hold dropped (R9)
    osc_fast_sel = 1;
    do_write(1, 1, 1, S_STOP, "R3 stop priority R9 no hold");
    do_wake("R6 wake from stop");
    hold_req = 0;
    // R4 timer beats sleep
    do_write(0, 0, 1, S_TMR, "R4 timer priority R7");
    do_wake("R6 wake from timer");
    // R5 irq pending blocks entry
    irq_pend = 1;
    do_write(0, 1, 1, S_RUN, "R5 irq blocks sleep");
    do_write(1, 1, 0, S_RUN, "R5 irq blocks stop");
    irq_pend = 0;
    // R12 empty request
    do_write(0, 1, 0, S_RUN, "R12 no request");
    // R3 stop alone
    do_write(1, 1, 0, S_STOP, "R3 stop alone");
    do_wake("R6 wake from stop 2");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items unchecked, expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run not finished, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule